// File: doc/BRIEF.md
# Counted Conditional Loop Branch Unit

This unit resolves the three short counted-loop branches in one step. It takes an opcode, a signed 8-bit displacement and the current count register. It reduces the count by one at the width that the address-size attribute selects, and tests the reduced value for zero. For the two qualified opcodes it also tests the zero flag. When the branch is taken, it forms the target from the fall-through address and the displacement. The target is cut to the operand width. The zero flag is only an input and the unit never changes it.

All results are captured in a register on the clock edge where the input strobe is high. They appear one cycle later together with an output-valid pulse. Any opcode outside the supported three is reported on a dedicated flag. In that case the count is left as it was and the fall-through address is passed on.

Top module: `loop_branch_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. All outputs are zero while `rst_n` is low.
- R2: `count_out` is `count_in` minus one at the count width. An `addr_size` of 0 selects 16 bits, and bits 63:16 pass through unchanged. An `addr_size` of 1 selects 32 bits, and bits 63:32 are cleared. Values 2 and 3 select the full 64 bits.
- R3: A count of zero within the selected width wraps to all ones in that width. That is a nonzero result, so it can branch.
- R4: Opcode 0xE2 is taken exactly when the reduced count is nonzero within the count width. The `zf` input has no effect on it.
- R5: Opcode 0xE1 is taken exactly when the reduced count is nonzero and `zf` is 1.
- R6: Opcode 0xE0 is taken exactly when the reduced count is nonzero and `zf` is 0.
- R7: When taken, `target_ip` is `next_ip` plus the sign-extended displacement, cut to the operand width, with the upper bits zero. The operand width is 64 bits when `long_mode` is 1. Otherwise an `op_size` of 0 gives 16 bits and any other value gives 32 bits.
- R8: When not taken, `target_ip` equals `next_ip` unchanged.
- R9: Any other opcode gives `unsupported` = 1, `taken` = 0, `count_out` = `count_in` and `target_ip` = `next_ip`. For the three supported opcodes `unsupported` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| opcode | input | 8 | Branch opcode |
| disp | input | 8 | Signed displacement |
| addr_size | input | 2 | Count width select: 0=16, 1=32, 2/3=64 |
| op_size | input | 2 | Operand width select outside 64-bit mode: 0=16, else 32 |
| long_mode | input | 1 | 64-bit mode; forces 64-bit operand width |
| count_in | input | 64 | Current count register |
| zf | input | 1 | Zero flag |
| next_ip | input | 64 | Address of next sequential instruction |
| out_valid | output | 1 | Results valid |
| count_out | output | 64 | Updated count register |
| taken | output | 1 | Branch taken |
| target_ip | output | 64 | Next instruction pointer |
| unsupported | output | 1 | Opcode is not one of the three loop branches |

## Verification
Two exit conditions can arise in the same cycle. One is the count reaching zero; the other is a zero flag that would otherwise allow the qualified branch. Directed vectors provoke this with a count of one, combined with a `zf` that matches 0xE1 or 0xE0. The result is judged correct only if the branch falls through and the count reads zero. A second directed case pairs the same timing with a zero count, where the wrap must still branch. Random vectors mix small counts, both flag values and all widths, and each result is compared against bench reference functions.

// File: rtl/loop_branch_unit.sv
module loop_branch_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [7:0]  disp,
  input  logic [1:0]  addr_size,
  input  logic [1:0]  op_size,
  input  logic        long_mode,
  input  logic [63:0] count_in,
  input  logic        zf,
  input  logic [63:0] next_ip,
  output logic        out_valid,
  output logic [63:0] count_out,
  output logic        taken,
  output logic [63:0] target_ip,
  output logic        unsupported
);

  localparam logic [7:0] OP_NZ  = 8'hE0;
  localparam logic [7:0] OP_Z   = 8'hE1;
  localparam logic [7:0] OP_ANY = 8'hE2;

  logic [63:0] cnt_mask, cnt_dec, cnt_new, tgt_sum, tgt_cut;
  logic        cnt_nz, known, go;

  always_comb begin
    unique case (addr_size)
      2'd0:    cnt_mask = 64'h0000_0000_0000_FFFF;
      2'd1:    cnt_mask = 64'h0000_0000_FFFF_FFFF;
      default: cnt_mask = '1;
    endcase
  end

  assign cnt_dec = count_in - 64'd1;

  always_comb begin
    unique case (addr_size)
      2'd0:    cnt_new = {count_in[63:16], cnt_dec[15:0]};
      2'd1:    cnt_new = {32'd0, cnt_dec[31:0]};
      default: cnt_new = cnt_dec;
    endcase
  end

  assign cnt_nz = |(cnt_new & cnt_mask);
  assign known  = (opcode == OP_NZ) || (opcode == OP_Z) || (opcode == OP_ANY);

  always_comb begin
    unique case (opcode)
      OP_ANY:  go = cnt_nz;
      OP_Z:    go = cnt_nz && zf;
      OP_NZ:   go = cnt_nz && !zf;
      default: go = 1'b0;
    endcase
  end

  assign tgt_sum = next_ip + {{56{disp[7]}}, disp};

  always_comb begin
    if (long_mode)          tgt_cut = tgt_sum;
    else if (op_size == 0)  tgt_cut = {48'd0, tgt_sum[15:0]};
    else                    tgt_cut = {32'd0, tgt_sum[31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      count_out   <= '0;
      taken       <= 1'b0;
      target_ip   <= '0;
      unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        count_out   <= known ? cnt_new : count_in;
        taken       <= go;
        target_ip   <= go ? tgt_cut : next_ip;
        unsupported <= !known;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && addr_size == 2'd0 |=> count_out[63:16] == $past(count_in[63:16]));

  // R5
  z_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode == OP_Z && !zf |=> !taken);

  // R6
  nz_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode == OP_NZ && zf |=> !taken);

  // R8
  fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || target_ip == $past(next_ip)));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && unsupported |-> !taken);

  // R9
  bad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !known |=> unsupported && count_out == $past(count_in));

endmodule

// File: tb/loop_branch_unit_bench.sv
module loop_branch_unit_bench;
  logic clk = 0, rst_n = 0, in_valid = 0, long_mode = 0, zf = 0;
  logic [7:0] opcode = 0, disp = 0;
  logic [1:0] addr_size = 0, op_size = 0;
  logic [63:0] count_in = 0, next_ip = 0;
  logic out_valid, taken, unsupported;
  logic [63:0] count_out, target_ip;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loop_branch_unit u_loop_branch_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .disp(disp),
    .addr_size(addr_size), .op_size(op_size), .long_mode(long_mode),
    .count_in(count_in), .zf(zf), .next_ip(next_ip), .out_valid(out_valid),
    .count_out(count_out), .taken(taken), .target_ip(target_ip),
    .unsupported(unsupported));

  function automatic logic [63:0] ref_count(logic [7:0] op, logic [1:0] asz, logic [63:0] c);
    if (op < 8'hE0 || op > 8'hE2) return c;
    case (asz)
      2'd0: return {c[63:16], 16'(c[15:0] - 16'd1)};
      2'd1: return {32'd0, 32'(c[31:0] - 32'd1)};
      default: return c - 64'd1;
    endcase
  endfunction

  function automatic bit ref_taken(logic [7:0] op, logic [1:0] asz, logic [63:0] c, logic z);
    logic [63:0] n;
    bit nz;
    n = ref_count(op, asz, c);
    nz = (asz == 0) ? (n[15:0] != 0) : (asz == 1) ? (n[31:0] != 0) : (n != 0);
    if (op == 8'hE2) return nz;
    if (op == 8'hE1) return nz && z;
    if (op == 8'hE0) return nz && !z;
    return 0;
  endfunction

  function automatic logic [63:0] ref_target(bit tk, logic [7:0] d, logic lm,
                                             logic [1:0] osz, logic [63:0] ip);
    logic [63:0] s;
    if (!tk) return ip;
    s = ip + {{56{d[7]}}, d};
    if (lm) return s;
    if (osz == 0) return {48'd0, s[15:0]};
    return {32'd0, s[31:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [7:0] op, logic [7:0] d, logic [1:0] asz, logic [1:0] osz,
                     logic lm, logic [63:0] c, logic z, logic [63:0] ip, string tag);
    logic [63:0] ec, et;
    bit tk;
    ec = ref_count(op, asz, c);
    tk = ref_taken(op, asz, c, z);
    et = ref_target(tk, d, lm, osz, ip);
    @(negedge clk);
    opcode = op; disp = d; addr_size = asz; op_size = osz; long_mode = lm;
    count_in = c; zf = z; next_ip = ip; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({"R1 out_valid ", tag}, 64'(out_valid), 64'd1);
    chk({"R2 count ", tag}, count_out, ec);
    chk({"R4/R5/R6 taken ", tag}, 64'(taken), 64'(tk));
    chk({tk ? "R7 target " : "R8 target ", tag}, target_ip, et);
    chk({"R9 unsupported ", tag}, 64'(unsupported),
        64'(op < 8'hE0 || op > 8'hE2));
    @(negedge clk);
    chk({"R1 valid drop ", tag}, 64'(out_valid), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    chk("R1 reset count", count_out, 64'd0);
    chk("R1 reset target", target_ip, 64'd0);
    rst_n = 1;
    // R3 wrap in each width
    run(8'hE2, 8'h05, 2'd0, 2'd0, 0, 64'hABCD_0000_1234_0000, 0, 64'h1000, "R3 wrap16");
    run(8'hE2, 8'h05, 2'd1, 2'd1, 0, 64'hFFFF_FFFF_0000_0000, 1, 64'h1000, "R3 wrap32");
    run(8'hE2, 8'hF0, 2'd2, 2'd0, 1, 64'd0, 0, 64'h8, "R3 wrap64");
    // R4 exit at one, zf ignored
    run(8'hE2, 8'h10, 2'd2, 2'd0, 1, 64'd1, 1, 64'h2000, "R4 exit");
    // R5 / R6 coincident exit: count hits zero while flag permits
    run(8'hE1, 8'h10, 2'd1, 2'd1, 0, 64'd1, 1, 64'h3000, "R5 coincide");
    run(8'hE0, 8'h10, 2'd0, 2'd0, 0, 64'h1_0001, 0, 64'h3000, "R6 coincide");
    run(8'hE1, 8'h80, 2'd1, 2'd1, 0, 64'd9, 1, 64'h50, "R5 taken back");
    run(8'hE1, 8'h80, 2'd1, 2'd1, 0, 64'd9, 0, 64'h50, "R5 blocked");
    run(8'hE0, 8'h7F, 2'd0, 2'd0, 0, 64'd9, 0, 64'hFFF0, "R6 taken wrap16");
    run(8'hE0, 8'h7F, 2'd0, 2'd0, 0, 64'd9, 1, 64'hFFF0, "R6 blocked");
    // R7 32-bit truncation and 64-bit sign extension
    run(8'hE2, 8'h20, 2'd1, 2'd1, 0, 64'd5, 0, 64'h1_FFFF_FFF0, "R7 trunc32");
    run(8'hE2, 8'hFE, 2'd3, 2'd0, 1, 64'd5, 0, 64'h1_0000_0000, "R7 sext64");
    // R9
    run(8'hE3, 8'h22, 2'd2, 2'd0, 1, 64'd7, 1, 64'h4000, "R9 E3");
    run(8'h00, 8'h22, 2'd0, 2'd0, 0, 64'd0, 0, 64'h4000, "R9 zero op");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [63:0] c;
      int sel;
      sel = $urandom_range(0, 9);
      op = (sel < 9) ? 8'hE0 + 8'($urandom_range(0, 2)) : 8'($urandom);
      c = ($urandom_range(0, 1) != 0) ? 64'($urandom_range(0, 3))
                                       : {$urandom, $urandom};
      run(op, 8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), c,
          1'($urandom), {$urandom, $urandom}, "random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule